// File: doc/BRIEF.md
# Dual Round-Robin Cell Scheduler

This block is the central scheduler of an input-queued cell switch with N inputs and N outputs. Every input holds one logical queue per output and reports which of them hold cells as a bit vector. At the start of each cell slot the scheduler runs one request/grant pass. Each input's request arbiter picks one non-empty queue in round-robin order, so each input raises at most one request. Each output's grant arbiter then picks one of the inputs that asked for it, also in round-robin order. There is no accept phase: a grant is a connection.

The two kinds of arbiter do the same circular priority search. They differ only in what they search over. An input's request pointer advances only when that input wins a grant. An output's grant pointer advances only when that output grants. Inputs that lost a slot keep their pointers, and winners move on to different outputs. Under heavy load this pulls the inputs apart until they no longer collide. The match is registered and appears one clock after the slot strobe, flagged by a valid pulse.

Top module: `drrm_sched`

## Requirements
- R1: Reset clears every request and grant pointer to index 0 and holds `match_valid` low and `match_grant` all zero.
- R2: Bit i*N+j of `voq_nonempty` means input i has cells for output j. An input's request arbiter targets the first set bit of its N-bit slice, searching circularly from its request pointer. It makes at most one request, and none when the slice is zero.
- R3: The grant arbiter of output j grants the first requesting input, searching circularly from output j's grant pointer.
- R4: `match_valid` is high for exactly the clock cycle after a cycle with `slot_start` high, and low otherwise.
- R5: Bit i*N+j of `match_grant` means input i is connected to output j. In any valid match, each input and each output has at most one grant. A grant appears only where input i's queue for output j was non-empty in the strobe cycle.
- R6: A request pointer moves to (chosen output + 1) mod N only when its input is granted; otherwise it keeps its value.
- R7: A grant pointer moves to (granted input + 1) mod N when its output grants, and keeps its value when the output receives no request.
- R8: In a cycle without `slot_start`, no pointer changes, and in the following cycle `match_grant` is zero.
- R9: With N=2, every queue full and all pointers at 0, the first slot connects input 0 to output 0 only. The next slot connects input 0 to output 1 and input 1 to output 0.
- R10: With every queue non-empty from reset, the match becomes a full permutation by the N-th slot and stays full every slot after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Strobe that runs one matching pass in this cycle |
| voq_nonempty | input | N*N | Queue occupancy, bit i*N+j for input i toward output j |
| match_valid | output | 1 | Registered match is present this cycle |
| match_grant | output | N*N | Registered grant matrix, bit i*N+j connects input i to output j |

## Verification
The bench builds two copies of the scheduler.

The copy with N=4 is compared slot by slot against a behavioural pointer model in the bench. It runs full load from reset, which makes the three-slot walk into a rotating full permutation observable. It also runs idle cycles, empty and single-queue patterns, and a long run of random occupancy that drives pointers to every wrap position.

The copy with N=2 reproduces the smallest collision case exactly. In that case both inputs request the same output, one input loses, and the two inputs then split across the outputs.

// File: rtl/drrm_pkg.sv
package drrm_pkg;

    // Widest port count the scheduler is meant to be built with.
    localparam int unsigned MAX_PORTS = 64;

    // Circular offset inside a ring of n positions.
    function automatic int unsigned wrap_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned n);
        return (base + step) % n;
    endfunction

    // Position one beyond idx, wrapping at n.
    function automatic int unsigned wrap_next(input int unsigned idx,
                                              input int unsigned n);
        return (idx + 1 == n) ? 0 : idx + 1;
    endfunction

    // Index width for a ring of n positions, at least one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/drrm_rr_arbiter.sv
module drrm_rr_arbiter
    import drrm_pkg::*;
#(
    parameter  int N  = 4,
    localparam int PW = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          hit,
    output logic [PW-1:0] idx,
    output logic [N-1:0]  pick
);

    // Circular search starting at ptr: first set request wins.
    always_comb begin
        int unsigned pos;
        hit  = 1'b0;
        idx  = '0;
        pick = '0;
        for (int k = 0; k < N; k++) begin
            pos = wrap_add(32'(ptr), k, N);
            if (!hit && req[PW'(pos)]) begin
                hit             = 1'b1;
                idx             = PW'(pos);
                pick[PW'(pos)]  = 1'b1;
            end
        end
    end

    // R2
    pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick));

    // R5
    pick_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        (pick & ~req) == '0);

    // R2
    busy_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> hit);

endmodule

// File: rtl/drrm_rr_pointer.sv
module drrm_rr_pointer
    import drrm_pkg::*;
#(
    parameter  int N  = 4,
    localparam int PW = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bump,
    input  logic [PW-1:0] sel,
    output logic [PW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (bump)
            ptr <= PW'(wrap_next(32'(sel), N));
    end

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(ptr));

    // R7
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < N);

endmodule

// File: rtl/drrm_sched.sv
module drrm_sched
    import drrm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_start,
    input  logic [N*N-1:0]   voq_nonempty,
    output logic             match_valid,
    output logic [N*N-1:0]   match_grant
);

    localparam int PW = idx_bits(N);

    logic [PW-1:0] req_ptr  [N];
    logic [PW-1:0] gnt_ptr  [N];
    logic          rq_hit   [N];
    logic [PW-1:0] rq_idx   [N];
    logic [N-1:0]  rq_vec   [N];
    logic [N-1:0]  col_req  [N];
    logic          gn_hit   [N];
    logic [PW-1:0] gn_idx   [N];
    logic [N-1:0]  gn_vec   [N];
    logic [N*N-1:0] grant_mx;
    logic [N-1:0]  in_won;

    // Request side: one arbiter and one pointer per input.
    for (genvar i = 0; i < N; i++) begin : g_input
        drrm_rr_arbiter #(.N(N)) u_req_arb (
            .clk (clk),
            .rst (rst),
            .req (voq_nonempty[i*N +: N]),
            .ptr (req_ptr[i]),
            .hit (rq_hit[i]),
            .idx (rq_idx[i]),
            .pick(rq_vec[i])
        );

        drrm_rr_pointer #(.N(N)) u_req_ptr (
            .clk (clk),
            .rst (rst),
            .bump(slot_start && in_won[i]),
            .sel (rq_idx[i]),
            .ptr (req_ptr[i])
        );
    end

    // Route each input's single request to the column of its output.
    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col_req[j][i] = rq_vec[i][j];
    end

    // Grant side: one arbiter and one pointer per output.
    for (genvar j = 0; j < N; j++) begin : g_output
        drrm_rr_arbiter #(.N(N)) u_gnt_arb (
            .clk (clk),
            .rst (rst),
            .req (col_req[j]),
            .ptr (gnt_ptr[j]),
            .hit (gn_hit[j]),
            .idx (gn_idx[j]),
            .pick(gn_vec[j])
        );

        drrm_rr_pointer #(.N(N)) u_gnt_ptr (
            .clk (clk),
            .rst (rst),
            .bump(slot_start && gn_hit[j]),
            .sel (gn_idx[j]),
            .ptr (gnt_ptr[j])
        );
    end

    // Gather grants back into input-major order.
    always_comb begin
        grant_mx = '0;
        in_won   = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                grant_mx[i*N + j] = gn_vec[j][i];
                in_won[i]         = in_won[i] | gn_vec[j][i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_grant <= '0;
        end else begin
            match_valid <= slot_start;
            match_grant <= slot_start ? grant_mx : '0;
        end
    end

    // R4
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> match_valid);

    // R4
    valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_start |=> !match_valid);

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_start |=> (match_grant == '0));

    // R5
    grant_only_occupied_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> ((match_grant & ~$past(voq_nonempty)) == '0));

    for (genvar i = 0; i < N; i++) begin : g_row_chk
        // R5
        row_single_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(match_grant[i*N +: N]));
    end

    for (genvar j = 0; j < N; j++) begin : g_col_chk
        logic [N-1:0] col_bits;
        always_comb
            for (int i = 0; i < N; i++)
                col_bits[i] = match_grant[i*N + j];
        // R5
        col_single_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col_bits));
    end

endmodule

// File: tb/drrm_sched_test.sv
`timescale 1ns/1ps
module drrm_sched_test;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          st4 = 1'b0;
    logic [15:0]   vq4 = '0;
    logic          mv4;
    logic [15:0]   mg4;

    logic          st2 = 1'b0;
    logic [3:0]    vq2 = '0;
    logic          mv2;
    logic [3:0]    mg2;

    int total = 0;
    int bad   = 0;
    int rp [N];
    int gp [N];

    drrm_sched #(.N(N)) uut (
        .clk(clk), .rst(rst), .slot_start(st4),
        .voq_nonempty(vq4), .match_valid(mv4), .match_grant(mg4));

    drrm_sched #(.N(2)) uut_pair (
        .clk(clk), .rst(rst), .slot_start(st2),
        .voq_nonempty(vq2), .match_valid(mv2), .match_grant(mg2));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural pointer model of one pass for N=4.
    task automatic model4(input logic [15:0] pat, output logic [15:0] exp);
        int want [N];
        exp = '0;
        for (int i = 0; i < N; i++) begin
            want[i] = -1;
            for (int k = 0; k < N; k++) begin
                int o = (rp[i] + k) % N;
                if (want[i] < 0 && pat[i*N + o]) want[i] = o;
            end
        end
        for (int j = 0; j < N; j++) begin
            bit done = 0;
            for (int k = 0; k < N; k++) begin
                int s = (gp[j] + k) % N;
                if (!done && want[s] == j) begin
                    done = 1;
                    exp[s*N + j] = 1'b1;
                    gp[j] = (s + 1) % N;
                    rp[s] = (j + 1) % N;
                end
            end
        end
    endtask

    task automatic slot4(input logic [15:0] pat, output logic [15:0] got);
        @(negedge clk);
        vq4 = pat;
        st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        check("R4 valid after strobe", 32'(mv4), 32'd1);
        got = mg4;
    endtask

    task automatic slot4_model(input string tag, input logic [15:0] pat);
        logic [15:0] got, exp;
        model4(pat, exp);
        slot4(pat, got);
        check(tag, 32'(got), 32'(exp));
    endtask

    task automatic test_reset;
        for (int i = 0; i < N; i++) begin rp[i] = 0; gp[i] = 0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid low after reset", 32'(mv4), 32'd0);
        check("R1 grants zero after reset", 32'(mg4), 32'd0);
    endtask

    task automatic test_idle;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            vq4 = 16'hA5C3 ^ 16'(c);
            check("R8 no valid while idle", 32'(mv4), 32'd0);
            check("R8 no grants while idle", 32'(mg4), 32'd0);
        end
    endtask

    task automatic test_full_load;
        logic [15:0] got, exp;
        for (int s = 1; s <= 8; s++) begin
            model4(16'hFFFF, exp);
            slot4(16'hFFFF, got);
            if (s == 1) check("R1 R3 first slot from zero pointers", 32'(got), 32'h0001);
            check("R6 R7 full load vs model", 32'(got), 32'(exp));
            if (s >= N) check("R10 full permutation", $countones(got), N);
        end
        @(negedge clk);
        check("R4 valid single cycle", 32'(mv4), 32'd0);
    endtask

    task automatic test_sparse;
        logic [15:0] got, exp;
        model4(16'h0000, exp);
        slot4(16'h0000, got);
        check("R2 empty queues give no grant", 32'(got), 32'h0000);
        model4(16'h0800, exp);
        slot4(16'h0800, got);
        check("R2 R3 single queue input2 to output3", 32'(got), 32'h0800);
        check("R2 single queue vs model", 32'(got), 32'(exp));
    endtask

    task automatic test_random;
        for (int s = 0; s < 40; s++) begin
            logic [15:0] pat, got, exp;
            pat = 16'($urandom());
            model4(pat, exp);
            slot4(pat, got);
            check("R2 R3 R6 R7 random vs model", 32'(got), 32'(exp));
            check("R5 grants only occupied", 32'(got & ~pat), 32'd0);
            for (int i = 0; i < N; i++)
                check("R5 one grant per input", 32'($countones(got[i*N +: N]) <= 1), 32'd1);
            for (int j = 0; j < N; j++) begin
                int c = 0;
                for (int i = 0; i < N; i++) c += int'(got[i*N + j]);
                check("R5 one grant per output", 32'(c <= 1), 32'd1);
            end
        end
    endtask

    task automatic test_pair;
        logic [3:0] want [3];
        want[0] = 4'b0001;
        want[1] = 4'b0110;
        want[2] = 4'b1001;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            vq2 = 4'hF;
            st2 = 1'b1;
            @(negedge clk);
            st2 = 1'b0;
            check("R9 two by two valid", 32'(mv2), 32'd1);
            check("R9 two by two desync", 32'(mg2), 32'(want[s]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R4 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(7));
        test_reset;
        test_idle;
        test_full_load;
        test_sparse;
        test_random;
        test_pair;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule